// File: doc/BRIEF.md
# Saturating Residual Reconstruction Stage

This block rebuilds an 8x8 block of 8-bit pixels from a predicted block and a block of signed 16-bit residuals. Each beat carries four predicted pixels and the four residuals that go with them, lane for lane. The sixteen beats of a block arrive in raster order: two 4-pixel groups per row, eight rows. For each lane the stage zero-extends the pixel and adds the residual. The sum saturates to the signed 16-bit range and is then clamped to 0..255. The stage sends out one reconstructed 4-pixel beat for each input beat, in the same order.

A residual-enable input is sampled on the first beat of each block and applies to the whole block. When it is low, the block carries no residual: the predicted pixels pass through unchanged and the residual lanes are ignored.

Both streams use valid/ready handshakes.
- A beat moves on a clock edge where valid and ready are both high.
- The output side holds its valid, data and last flag steady until it is taken.
- The input ready signal is high when the output register is empty or is being emptied in the same cycle. So with the sink always ready, the stage accepts one beat per cycle, and each result appears in the cycle after its input is accepted.
- The stage raises the last flag on the sixteenth output beat of each block.

Top module: `recon_sat_add`

## Requirements
- R1: While reset is held and in the first cycle after it is released, m_valid is 0 and s_ready is 1.
- R2: For a block with residuals enabled, output lane i (m_pix bits [8i+7:8i]) equals the clamp to 0..255 of the unsigned pixel s_pix[8i+7:8i] plus the signed residual s_res[16i+15:16i], for i = 0..3.
- R3: In every lane, a sum below zero gives 0. This includes a sum of exactly -1 and a residual of -32768.
- R4: In every lane, a sum above 255 gives 255. This includes a sum of exactly 256 and a sum that saturates at 32767. A sum of exactly 255 or exactly 0 passes as is.
- R5: When s_res_en is 0 on the first beat of a block, every output lane of that block equals its input pixel, whatever the residual.
- R6: s_res_en is sampled only on the first beat (beat 0) of each block. Its value on beats 1 to 15 has no effect on that block's output.
- R7: m_last is 1 on the 16th output beat of each block and 0 on the other fifteen.
- R8: While m_valid is 1 and m_ready is 0, m_pix and m_last hold steady and s_ready is 0. No beat is lost or repeated under back-pressure.
- R9: s_ready is 1 whenever the output register is empty or m_ready is 1. A beat accepted at an edge shows m_valid = 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | An input beat is offered |
| s_ready | output | 1 | The stage can take an input beat |
| s_res_en | input | 1 | Residuals present for this block (sampled on beat 0) |
| s_pix | input | 32 | Four predicted pixels, lane i at bits [8i+7:8i] |
| s_res | input | 64 | Four signed residuals, lane i at bits [16i+15:16i] |
| m_valid | output | 1 | An output beat is held |
| m_ready | input | 1 | The sink takes the output beat |
| m_pix | output | 32 | Four reconstructed pixels, lane i at bits [8i+7:8i] |
| m_last | output | 1 | The output beat is the last of its block |

## Verification
The hardest case to reach from the ports is a clamp edge that lands in a chosen lane while the output is stalled and s_res_en changes in the middle of a block.
- The clamp edges are covered by a full sweep of all 256 pixel values. Each lane gets a residual that lands exactly on -1, 0, 255 or 256, and the lane assignment rotates from block to block so that every lane meets every edge.
- Further blocks drive the residual extremes, toggle the enable after beat 0 in both directions, and repeat under a sink that is ready only two cycles in three and a source that leaves gaps.
- During those stalls the bench checks that the held data stay steady and that no beat is lost.

// File: rtl/recon_pkg.sv
`timescale 1ns/1ps
package recon_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_PIX_W = 8;
  localparam int unsigned DEF_RES_W = 16;
  localparam int unsigned DEF_ROWS  = 8;
  localparam int unsigned DEF_COLS  = 8;

  function automatic int unsigned beats_per_block(int unsigned rows, int unsigned cols,
                                                  int unsigned lanes);
    return (rows * cols) / lanes;
  endfunction
endpackage

// File: rtl/recon_lane.sv
`timescale 1ns/1ps
module recon_lane #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned RES_W = 16
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [RES_W-1:0] res,
  input  logic             use_res,
  output logic [PIX_W-1:0] q
);
  localparam int unsigned SW = RES_W + 1;
  localparam logic signed [SW-1:0] S_MAX = signed'({2'b00, {(RES_W-1){1'b1}}});
  localparam logic signed [SW-1:0] S_MIN = signed'({2'b11, {(RES_W-1){1'b0}}});

  logic signed [SW-1:0] ext_pix;
  logic signed [SW-1:0] ext_res;
  logic signed [SW-1:0] wide;
  logic [RES_W-1:0]     sat;
  logic [PIX_W-1:0]     clip;

  // widen both operands by one bit so the sum cannot wrap
  always_comb begin
    ext_pix = signed'({{(SW-PIX_W){1'b0}}, pix});
    ext_res = signed'({res[RES_W-1], res});
    wide    = ext_pix + ext_res;
  end

  // saturate to the signed residual range
  always_comb begin
    if (wide > S_MAX)      sat = {1'b0, {(RES_W-1){1'b1}}};
    else if (wide < S_MIN) sat = {1'b1, {(RES_W-1){1'b0}}};
    else                   sat = wide[RES_W-1:0];
  end

  // clamp to the unsigned pixel range
  always_comb begin
    if (sat[RES_W-1])               clip = '0;
    else if (|sat[RES_W-2:PIX_W])   clip = '1;
    else                            clip = sat[PIX_W-1:0];
  end

  assign q = use_res ? clip : pix;
endmodule

// File: rtl/recon_beat_ctr.sv
`timescale 1ns/1ps
module recon_beat_ctr #(
  parameter int unsigned BEATS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic first,
  output logic final_beat
);
  localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

  logic [CW-1:0] cnt_q;

  assign first      = (cnt_q == '0);
  assign final_beat = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (adv)  cnt_q <= final_beat ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/recon_out_reg.sv
`timescale 1ns/1ps
module recon_out_reg #(
  parameter int unsigned W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         load;

  assign in_ready  = !vld_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld_q <= 1'b0;
    else if (in_ready)  vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dat_q <= '0;
    else if (load)  dat_q <= in_data;
  end
endmodule

// File: rtl/recon_sat_add.sv
`timescale 1ns/1ps
module recon_sat_add
  import recon_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned PIX_W = DEF_PIX_W,
  parameter int unsigned RES_W = DEF_RES_W,
  parameter int unsigned ROWS  = DEF_ROWS,
  parameter int unsigned COLS  = DEF_COLS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic                   s_res_en,
  input  logic [LANES*PIX_W-1:0] s_pix,
  input  logic [LANES*RES_W-1:0] s_res,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [LANES*PIX_W-1:0] m_pix,
  output logic                   m_last
);
  localparam int unsigned BEATS = beats_per_block(ROWS, COLS, LANES);
  localparam int unsigned DW    = LANES * PIX_W;

  logic          accept;
  logic          first;
  logic          final_beat;
  logic          blk_en_q;
  logic          eff_en;
  logic [DW-1:0] recon;
  logic [DW:0]   out_word;

  assign accept = s_valid && s_ready;

  recon_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (accept),
    .first      (first),
    .final_beat (final_beat)
  );

  // block-wide residual enable, captured on beat 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blk_en_q <= 1'b0;
    else if (accept && first)   blk_en_q <= s_res_en;
  end

  assign eff_en = first ? s_res_en : blk_en_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    recon_lane #(.PIX_W(PIX_W), .RES_W(RES_W)) u_lane (
      .pix     (s_pix[i*PIX_W +: PIX_W]),
      .res     (s_res[i*RES_W +: RES_W]),
      .use_res (eff_en),
      .q       (recon[i*PIX_W +: PIX_W])
    );
  end

  recon_out_reg #(.W(DW + 1)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   ({final_beat, recon}),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (out_word)
  );

  assign m_pix  = out_word[DW-1:0];
  assign m_last = out_word[DW];
endmodule

// File: rtl/recon_sat_add_chk.sv
`timescale 1ns/1ps
module recon_sat_add_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned COLS  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic                   m_valid,
  input logic                   m_ready,
  input logic [LANES*PIX_W-1:0] m_pix,
  input logic                   m_last
);
  localparam int unsigned BEATS = (ROWS * COLS) / LANES;
  localparam int unsigned CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CW-1:0] out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_cnt <= '0;
    else if (m_valid && m_ready)
      out_cnt <= (out_cnt == CW'(BEATS - 1)) ? '0 : out_cnt + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix) && $stable(m_last)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R9
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  // R7
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_last == (out_cnt == CW'(BEATS - 1))));
endmodule

bind recon_sat_add recon_sat_add_chk #(
  .LANES (LANES),
  .PIX_W (PIX_W),
  .ROWS  (ROWS),
  .COLS  (COLS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_pix   (m_pix),
  .m_last  (m_last)
);

// File: tb/recon_sat_add_tb.sv
`timescale 1ns/1ps
module recon_sat_add_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic        s_res_en;
  logic [31:0] s_pix;
  logic [63:0] s_res;
  logic        m_valid;
  logic        m_ready;
  logic [31:0] m_pix;
  logic        m_last;

  always #2.5 clk = ~clk;

  recon_sat_add u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_res_en(s_res_en), .s_pix(s_pix), .s_res(s_res),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix), .m_last(m_last)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int in_beat = 0;
  bit blk_en = 1'b0;
  bit stall_mode = 1'b0;
  bit gap_mode = 1'b0;
  bit acc_prev = 1'b0;
  bit held = 1'b0;
  bit done = 1'b0;
  logic [32:0] held_word;
  logic [31:0] exp_q[$];
  bit          exp_last_q[$];
  logic [15:0] exp_code_q[$];

  function automatic logic [7:0] model(logic [7:0] p, logic [15:0] r);
    int s;
    s = int'(p) + int'($signed(r));
    if (s < 0) return 8'd0;
    if (s > 255) return 8'd255;
    return 8'(s);
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] p, input logic [63:0] r,
                      input bit en, input logic [15:0] code, output bit acc);
    logic [31:0] e;
    @(negedge clk);
    cyc++;
    m_ready  = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    s_valid  = v;
    s_pix    = p;
    s_res    = r;
    s_res_en = en;
    #1;
    if (acc_prev) chk(m_valid, "R9", "m_valid after accept", 64'(m_valid), 64'd1);
    if (!stall_mode) chk(s_ready, "R9", "s_ready with sink ready", 64'(s_ready), 64'd1);
    if (held) chk({m_last, m_pix} == held_word, "R8", "held data",
                  64'({m_last, m_pix}), 64'(held_word));
    held = 1'b0;
    if (m_valid && !m_ready) begin
      chk(!s_ready, "R8", "s_ready during stall", 64'(s_ready), 64'd0);
      held = 1'b1;
      held_word = {m_last, m_pix};
    end
    if (m_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected output beat", 64'(m_pix), 64'd0);
      end else begin
        for (int i = 0; i < 4; i++)
          chk(m_pix[8*i +: 8] == exp_q[0][8*i +: 8], tag(exp_code_q[0][4*i +: 4]),
              $sformatf("lane %0d", i), 64'(m_pix[8*i +: 8]), 64'(exp_q[0][8*i +: 8]));
        chk(m_last == exp_last_q[0], "R7", "m_last", 64'(m_last), 64'(exp_last_q[0]));
        if (m_ready) begin
          void'(exp_q.pop_front());
          void'(exp_last_q.pop_front());
          void'(exp_code_q.pop_front());
        end
      end
    end
    acc = v && s_ready;
    acc_prev = acc;
    if (acc) begin
      if (in_beat == 0) blk_en = en;
      for (int i = 0; i < 4; i++)
        e[8*i +: 8] = blk_en ? model(p[8*i +: 8], r[16*i +: 16]) : p[8*i +: 8];
      exp_q.push_back(e);
      exp_last_q.push_back(in_beat == 15);
      exp_code_q.push_back(code);
      in_beat = (in_beat == 15) ? 0 : in_beat + 1;
    end
  endtask

  task automatic push_beat(logic [31:0] p, logic [63:0] r, bit en, logic [15:0] code);
    bit acc;
    if (gap_mode && (cyc % 5 == 0)) step(1'b0, 32'd0, 64'd0, 1'b0, 16'd0, acc);
    acc = 1'b0;
    while (!acc) step(1'b1, p, r, en, code, acc);
  endtask

  function automatic logic [15:0] small_res(int n);
    case (n % 8)
      0: return 16'd0;
      1: return 16'd5;
      2: return 16'(-5);
      3: return 16'd90;
      4: return 16'(-90);
      5: return 16'd127;
      6: return 16'(-128);
      default: return 16'd300;
    endcase
  endfunction

  task automatic mixed_block(int b, bit en, logic [3:0] c);
    logic [31:0] p;
    logic [63:0] r;
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 4; i++) begin
        p[8*i +: 8]   = 8'((k * 37 + i * 91 + b * 13) & 255);
        r[16*i +: 16] = small_res(k + i + b);
      end
      push_beat(p, r, en, {c, c, c, c});
    end
  endtask

  initial begin
    bit acc;
    logic [31:0] p;
    logic [63:0] r;
    logic [15:0] code;
    int pv;
    int v;
    rst_n = 1'b0; s_valid = 1'b0; s_res_en = 1'b0; s_pix = '0; s_res = '0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid, "R1", "m_valid in reset", 64'(m_valid), 64'd0);
    chk(s_ready, "R1", "s_ready in reset", 64'(s_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!m_valid, "R1", "m_valid after reset", 64'(m_valid), 64'd0);
    chk(s_ready, "R1", "s_ready after reset", 64'(s_ready), 64'd1);

    // R3 R4: all pixel values, each lane hitting -1, 0, 255 and 256 sums
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < 16; k++) begin
        pv = b * 16 + k;
        for (int i = 0; i < 4; i++) begin
          v = (i + b) % 4;
          p[8*i +: 8] = 8'(pv);
          case (v)
            0: r[16*i +: 16] = 16'(-pv);
            1: r[16*i +: 16] = 16'(-pv - 1);
            2: r[16*i +: 16] = 16'(255 - pv);
            default: r[16*i +: 16] = 16'(256 - pv);
          endcase
          code[4*i +: 4] = (v < 2) ? 4'd3 : 4'd4;
        end
        push_beat(p, r, 1'b1, code);
      end
    end

    // R3 R4: residual extremes with saturation
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 4; i++) begin
        if (((k + i) % 2) == 0) begin
          p[8*i +: 8] = 8'(255 - k);
          r[16*i +: 16] = 16'(32767 - i);
          code[4*i +: 4] = 4'd4;
        end else begin
          p[8*i +: 8] = 8'(k * 16);
          r[16*i +: 16] = 16'(-32768 + i);
          code[4*i +: 4] = 4'd3;
        end
      end
      push_beat(p, r, 1'b1, code);
    end

    // R2: general values
    mixed_block(0, 1'b1, 4'd2);
    mixed_block(1, 1'b1, 4'd2);

    // R5: bypass with large residuals
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 4; i++) begin
        p[8*i +: 8] = 8'(k * 17 + i * 60);
        r[16*i +: 16] = (i % 2 == 0) ? 16'd32767 : 16'(-32768);
      end
      push_beat(p, r, 1'b0, 16'h5555);
    end

    // R6: enable sampled on beat 0 only, toggled in both directions
    for (int blk = 0; blk < 2; blk++) begin
      for (int k = 0; k < 16; k++) begin
        for (int i = 0; i < 4; i++) begin
          p[8*i +: 8] = 8'(200 + k + i);
          r[16*i +: 16] = (i < 2) ? 16'd100 : 16'(-250);
        end
        push_beat(p, r, (k == 0) ? (blk == 0) : (blk != 0), 16'h6666);
      end
    end

    // R8: back-pressure and source gaps
    stall_mode = 1'b1;
    gap_mode = 1'b1;
    mixed_block(2, 1'b1, 4'd2);
    mixed_block(3, 1'b0, 4'd5);
    mixed_block(4, 1'b1, 4'd2);
    stall_mode = 1'b0;
    gap_mode = 1'b0;
    for (int n = 0; n < 100 && exp_q.size() != 0; n++)
      step(1'b0, 32'd0, 64'd0, 1'b0, 16'd0, acc);
    chk(exp_q.size() == 0, "R8", "beats outstanding", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule